// File: doc/BRIEF.md
# Serial EEPROM Device Model with Ready/Busy Pin

This block models the target end of a four-wire serial EEPROM that holds 2 Kbit of data. A host selects the device with a chip-select line and then clocks a start bit, a two-bit operation code and an address into the data input. A write-type command then takes a data word. A read command returns data on the data output pin with an output enable. A separate ready pin goes low while a self-timed programming delay runs. That delay is counted in system clocks.

The serial clock, chip select, data input and organization pin are all oversampled by a faster system clock through two-flop synchronizers, and the block acts on rising serial-clock edges that it finds in the system clock domain. The array is stored as bytes. The organization pin selects one of two views of it. When the pin is low, the array is 256 eight-bit locations. When the pin is high, it is 128 sixteen-bit words. An unconnected pin is meant to read as high, so the board should pull it up. Programming commands are refused until an enable command sets a protection latch. Reset clears that latch.

Top module: `sereep_target`

## Requirements
- R1: After reset, ready_o is 1 and sdo_oe_o is 0. The programming latch is clear, so a programming command issued before any enable command leaves ready_o at 1.
- R2: A frame starts after chip select goes high. Zero bits before the first 1 are skipped. The first 1 is the start bit. Two opcode bits follow, then the address, all MSB first and sampled on rising serial-clock edges. The address is 8 bits when org_i is 0 and 7 bits when org_i is 1.
- R3: Opcode 10 is a read. On the rising edge that samples the last address bit, sdo_o drives a dummy 0. Each later rising edge shifts out one bit of the word, MSB first. The word is 16 bits when org_i is 1 and 8 bits when org_i is 0. Sixteen-bit word w occupies byte 2w (high half) and byte 2w+1 (low half).
- R4: Opcodes 01 and 11 are a write. A data word of the current width follows the address, and it is stored at that address when the latch is set.
- R5: Opcode 00 takes its sub-command from the two most significant address bits. Sub-command 11 sets the latch and 00 clears it. While the latch is clear, write, erase-all and write-all change nothing, but reads still work.
- R6: Opcode 00 with sub-command 10 (erase all) sets every bit of the array to 1.
- R7: Opcode 00 with sub-command 01 (write all) takes a data word and copies it into every location of the current organization.
- R8: An accepted programming command drives ready_o to 0 within a few system clocks after its final bit. ready_o stays 0 for exactly PROG_CYCLES system clocks and then returns to 1.
- R9: If the start bit of a frame arrives while ready_o is 0, that whole frame is ignored.
- R10: If chip select falls before a frame is complete, the partial frame is discarded and no programming starts.
- R11: sdo_oe_o is 0 whenever the synchronized chip select is low. It is 1 only from the dummy bit of a read until chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the device |
| org_i | input | 1 | Organization select: 1 for 16-bit words, 0 for bytes |
| sdo_o | output | 1 | Serial data out of the device |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high impedance |
| ready_o | output | 1 | 1 when idle, 0 while programming |

## Verification
Two events can meet in the same cycle: the programming timer is still running when the start bit of a new frame is decoded. The bench provokes this by opening a second write to the same word right after the first one, so that its start bit lands inside the busy window. It first checks that ready_o is still low at the end of the first frame. It then judges the outcome at the ports: ready_o must come back without a second busy period, and a later read must return the first data word, not the second. A checker also confirms that no command is ever issued while ready_o is low, and that each busy period lasts exactly PROG_CYCLES clocks.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  typedef enum logic [2:0] {
    K_READ,
    K_WRITE,
    K_EWEN,
    K_EWDS,
    K_ERAL,
    K_WRAL
  } cmd_kind_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_OP,
    F_ADDR,
    F_DATA,
    F_RD,
    F_DONE
  } frame_st_e;

endpackage

// File: rtl/sereep_sync.sv
module sereep_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/sereep_frame.sv
module sereep_frame
  import sereep_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              rise,
  input  logic              sdi_s,
  input  logic              org16,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_valid,
  output cmd_kind_e         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int HALF_W = WORD_W / 2;

  frame_st_e         st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [1:0]        opc, opc_n;
  logic [ADDR_W-1:0] adr, adr_n, adr_sh;
  logic [WORD_W-1:0] dat, dat_n, rsh, rsh_n;
  logic              sdo_n, oe_n, cmdv_n;
  cmd_kind_e         kind_n;
  logic [CNT_W-1:0]  aw, dw;
  logic [1:0]        sub;

  assign aw      = org16 ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
  assign dw      = org16 ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
  assign adr_sh  = {adr[ADDR_W-2:0], sdi_s};
  assign sub     = org16 ? adr_sh[ADDR_W-2 -: 2] : adr_sh[ADDR_W-1 -: 2];
  assign rd_addr = adr_sh;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    opc_n  = opc;
    adr_n  = adr;
    dat_n  = dat;
    rsh_n  = rsh;
    sdo_n  = sdo;
    oe_n   = sdo_oe;
    cmdv_n = 1'b0;
    kind_n = cmd_kind;
    if (!cs_s) begin
      st_n  = F_IDLE;
      sdo_n = 1'b0;
      oe_n  = 1'b0;
    end else if (rise) begin
      unique case (st)
        F_IDLE: if (sdi_s) begin
          st_n  = busy ? F_DONE : F_OP;
          cnt_n = '0;
          adr_n = '0;
          dat_n = '0;
        end
        F_OP: begin
          opc_n = {opc[0], sdi_s};
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(1)) begin
            st_n  = F_ADDR;
            cnt_n = '0;
          end
        end
        F_ADDR: begin
          adr_n = adr_sh;
          cnt_n = cnt + 1'b1;
          if (cnt == aw - 1'b1) begin
            cnt_n = '0;
            st_n  = F_DONE;
            if (opc == 2'b10) begin
              rsh_n = org16 ? rd_word : (rd_word << HALF_W);
              sdo_n = 1'b0;
              oe_n  = 1'b1;
              st_n  = F_RD;
            end else if (opc[0]) begin
              kind_n = K_WRITE;
              st_n   = F_DATA;
            end else begin
              unique case (sub)
                2'b11: begin kind_n = K_EWEN; cmdv_n = 1'b1; end
                2'b00: begin kind_n = K_EWDS; cmdv_n = 1'b1; end
                2'b10: begin kind_n = K_ERAL; cmdv_n = 1'b1; end
                default: begin kind_n = K_WRAL; st_n = F_DATA; end
              endcase
            end
          end
        end
        F_DATA: begin
          dat_n = {dat[WORD_W-2:0], sdi_s};
          cnt_n = cnt + 1'b1;
          if (cnt == dw - 1'b1) begin
            cmdv_n = 1'b1;
            st_n   = F_DONE;
          end
        end
        F_RD: begin
          if (cnt < dw) begin
            sdo_n = rsh[WORD_W-1];
            rsh_n = rsh << 1;
            cnt_n = cnt + 1'b1;
          end else begin
            sdo_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= F_IDLE;
      cnt       <= '0;
      opc       <= '0;
      adr       <= '0;
      dat       <= '0;
      rsh       <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_kind  <= K_READ;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      opc       <= opc_n;
      adr       <= adr_n;
      dat       <= dat_n;
      rsh       <= rsh_n;
      sdo       <= sdo_n;
      sdo_oe    <= oe_n;
      cmd_valid <= cmdv_n;
      cmd_kind  <= kind_n;
    end
  end

  assign cmd_addr = adr;
  assign cmd_data = dat;
endmodule

// File: rtl/sereep_array.sv
module sereep_array
  import sereep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              org16,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word,
  input  logic              cmd_valid,
  input  cmd_kind_e         cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              busy,
  output logic              wel
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TC_W   = $clog2(PROG_CYCLES + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [TC_W-1:0]   tmr, tmr_n;
  logic              wel_n, is_prog, prog_ok;
  logic [ADDR_W-1:0] hi_a, lo_a, rhi_a, rlo_a;

  assign rhi_a   = {rd_addr[ADDR_W-2:0], 1'b0};
  assign rlo_a   = {rd_addr[ADDR_W-2:0], 1'b1};
  assign rd_word = org16 ? {mem[rhi_a], mem[rlo_a]} : {{BYTE_W{1'b0}}, mem[rd_addr]};

  assign hi_a    = {cmd_addr[ADDR_W-2:0], 1'b0};
  assign lo_a    = {cmd_addr[ADDR_W-2:0], 1'b1};
  assign busy    = (tmr != '0);
  assign is_prog = (cmd_kind == K_WRITE) || (cmd_kind == K_ERAL) || (cmd_kind == K_WRAL);
  assign prog_ok = cmd_valid && !busy && wel && is_prog;

  always_comb begin
    wel_n = wel;
    tmr_n = busy ? tmr - 1'b1 : tmr;
    if (cmd_valid && !busy) begin
      if (cmd_kind == K_EWEN) wel_n = 1'b1;
      if (cmd_kind == K_EWDS) wel_n = 1'b0;
    end
    if (prog_ok) tmr_n = TC_W'(PROG_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
      tmr <= '0;
    end else begin
      wel <= wel_n;
      tmr <= tmr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (prog_ok) begin
      for (int i = 0; i < DEPTH; i++) begin
        unique case (cmd_kind)
          K_ERAL: mem[i] <= '1;
          K_WRAL: mem[i] <= (org16 && !i[0]) ? cmd_data[WORD_W-1:BYTE_W] : cmd_data[BYTE_W-1:0];
          K_WRITE: begin
            if (org16) begin
              if (ADDR_W'(i) == hi_a) mem[i] <= cmd_data[WORD_W-1:BYTE_W];
              if (ADDR_W'(i) == lo_a) mem[i] <= cmd_data[BYTE_W-1:0];
            end else if (ADDR_W'(i) == cmd_addr) begin
              mem[i] <= cmd_data[BYTE_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sereep_target.sv
module sereep_target
  import sereep_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic org_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic ready_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [3:0]        pins_s;
  logic              cs_s, sclk_s, sdi_s, org16, sclk_d, rise;
  logic [ADDR_W-1:0] rd_addr, cmd_addr;
  logic [WORD_W-1:0] rd_word, cmd_data;
  logic              cmd_valid, busy, wel;
  cmd_kind_e         cmd_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sereep_sync #(.W(4)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    ({cs_i, sclk_i, sdi_i, org_i}),
    .q    (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s, org16} = pins_s;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_d <= 1'b0;
    else             sclk_d <= sclk_s;
  end
  assign rise = sclk_s && !sclk_d;

  sereep_frame #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_s     (cs_s),
    .rise     (rise),
    .sdi_s    (sdi_s),
    .org16    (org16),
    .busy     (busy),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .sdo      (sdo_o),
    .sdo_oe   (sdo_oe_o)
  );

  sereep_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .org16    (org16),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .busy     (busy),
    .wel      (wel)
  );

  assign ready_o = !busy;
endmodule

// File: rtl/sereep_chk.sv
module sereep_chk
  import sereep_pkg::*;
#(
  parameter int PROG_CYCLES = 500
) (
  input logic      clk,
  input logic      rst_sync_n,
  input logic      cs_s,
  input logic      sdo_oe_o,
  input logic      ready_o,
  input logic      cmd_valid,
  input cmd_kind_e cmd_kind,
  input logic      wel
);
  int low_cnt;
  logic prog_cmd;

  assign prog_cmd = cmd_valid &&
                    ((cmd_kind == K_WRITE) || (cmd_kind == K_ERAL) || (cmd_kind == K_WRAL));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   low_cnt <= 0;
    else if (!ready_o) low_cnt <= low_cnt + 1;
    else               low_cnt <= 0;
  end

  a_r11_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs_s |=> !sdo_oe_o);

  a_r9_no_command_while_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ready_o |-> !cmd_valid);

  a_r5_locked_prog_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prog_cmd && !wel && ready_o) |=> ready_o);

  a_r8_busy_exact_length: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ready_o) |-> (low_cnt == PROG_CYCLES));

  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_sync_n)
    low_cnt <= PROG_CYCLES);
endmodule

bind sereep_target sereep_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .cs_s      (cs_s),
  .sdo_oe_o  (sdo_oe_o),
  .ready_o   (ready_o),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .wel       (wel)
);

// File: tb/test_sereep_target.sv
`timescale 1ns/1ps
module test_sereep_target;
  localparam int PROG = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b1;
  logic sdo, oe, ready;
  int checks = 0, failures = 0, cyc = 0;
  logic last_ready;

  always #2.5 clk = ~clk;

  sereep_target #(.PROG_CYCLES(PROG)) i_sereep_target (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi),
    .org_i(org), .sdo_o(sdo), .sdo_oe_o(oe), .ready_o(ready)
  );

  // fields: wr_org, wr_addr, wr_data, rd_org, rd_addr, expected
  localparam logic [49:0] VEC [0:5] = '{
    {1'b1, 8'h05, 16'hA1B2, 1'b1, 8'h05, 16'hA1B2},
    {1'b1, 8'h7F, 16'h1234, 1'b1, 8'h7F, 16'h1234},
    {1'b0, 8'hFF, 16'h00C5, 1'b0, 8'hFF, 16'h00C5},
    {1'b0, 8'h00, 16'h003C, 1'b0, 8'h00, 16'h003C},
    {1'b1, 8'h10, 16'hBEEF, 1'b0, 8'h21, 16'h00EF},
    {1'b1, 8'h10, 16'hBEEF, 1'b0, 8'h20, 16'h00BE}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdi = b;  wait_n(6);
    sclk = 1; wait_n(6);
    sclk = 0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic sel(input logic o);
    org = o; wait_n(4);
    cs = 1;  wait_n(4);
  endtask

  task automatic desel();
    cs = 0; sdi = 0; wait_n(8);
  endtask

  function automatic int awid(input logic o);
    return o ? 7 : 8;
  endfunction

  function automatic int dwid(input logic o);
    return o ? 16 : 8;
  endfunction

  task automatic do_write(input logic o, input logic [7:0] a, input logic [15:0] d);
    sel(o);
    send(3'b101, 3);
    send({24'h0, a}, awid(o));
    send({16'h0, d}, dwid(o));
    last_ready = ready;
    desel();
  endtask

  task automatic do_ext(input logic o, input logic [1:0] sb, input logic with_data,
                        input logic [15:0] d);
    sel(o);
    send(3'b100, 3);
    send({30'h0, sb}, 2);
    send(32'h0, awid(o) - 2);
    if (with_data) send({16'h0, d}, dwid(o));
    last_ready = ready;
    desel();
  endtask

  task automatic do_read(input logic o, input logic [7:0] a, input int lead0,
                         output logic [15:0] v, output logic dmy, output logic oe_seen);
    sel(o);
    if (lead0 > 0) send(32'h0, lead0);
    send(3'b110, 3);
    send({24'h0, a}, awid(o));
    wait_n(2);
    dmy = sdo;
    oe_seen = oe;
    v = '0;
    for (int i = 0; i < dwid(o); i++) begin
      sclk = 1; wait_n(6);
      v = {v[14:0], sdo};
      sclk = 0; wait_n(6);
    end
    desel();
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic dmy, oes;
    int n;

    wait_n(5);
    rst_n = 1;
    wait_n(5);
    chk("R1 ready after reset", {15'h0, ready}, 16'h1);
    chk("R1 oe after reset", {15'h0, oe}, 16'h0);

    // R1/R5: programming with the latch clear does not start a busy period
    do_ext(1'b1, 2'b10, 1'b0, 16'h0);
    chk("R1 erase-all refused before enable", {15'h0, last_ready}, 16'h1);
    wait_n(4);
    chk("R1 still ready", {15'h0, ready}, 16'h1);

    // R6 erase all
    do_ext(1'b1, 2'b11, 1'b0, 16'h0);
    do_ext(1'b1, 2'b10, 1'b0, 16'h0);
    chk("R8 busy after erase-all", {15'h0, last_ready}, 16'h0);
    wait_ready(n);
    do_read(1'b1, 8'h7F, 0, v, dmy, oes);
    chk("R6 erased word 7F", v, 16'hFFFF);
    do_read(1'b0, 8'h00, 0, v, dmy, oes);
    chk("R6 erased byte 00", v, 16'h00FF);

    // R5: disable, write refused, read still works
    do_ext(1'b1, 2'b00, 1'b0, 16'h0);
    do_write(1'b1, 8'h33, 16'h1111);
    chk("R5 write refused when disabled", {15'h0, last_ready}, 16'h1);
    do_read(1'b1, 8'h33, 0, v, dmy, oes);
    chk("R5 read while disabled", v, 16'hFFFF);

    // vector table: R2, R3, R4
    do_ext(1'b1, 2'b11, 1'b0, 16'h0);
    for (int k = 0; k < 6; k++) begin
      do_write(VEC[k][49], VEC[k][48:41], VEC[k][40:25]);
      chk("R8 ready low after write", {15'h0, last_ready}, 16'h0);
      wait_ready(n);
      do_read(VEC[k][24], VEC[k][23:16], 0, v, dmy, oes);
      chk("R4 R3 vector readback", v, VEC[k][15:0]);
      chk("R3 dummy bit", {15'h0, dmy}, 16'h0);
      chk("R11 oe during read", {15'h0, oes}, 16'h1);
    end
    wait_n(4);
    chk("R11 oe off after deselect", {15'h0, oe}, 16'h0);

    // R7 write all
    do_ext(1'b1, 2'b01, 1'b1, 16'h5AC3);
    wait_ready(n);
    do_read(1'b1, 8'h03, 0, v, dmy, oes);
    chk("R7 write-all word 03", v, 16'h5AC3);
    do_read(1'b0, 8'h10, 0, v, dmy, oes);
    chk("R7 write-all byte 10", v, 16'h005A);
    do_read(1'b0, 8'h11, 0, v, dmy, oes);
    chk("R7 write-all byte 11", v, 16'h00C3);

    // R8 / R9: second write starts while busy
    do_write(1'b1, 8'h02, 16'h1357);
    chk("R8 ready low after final bit", {15'h0, last_ready}, 16'h0);
    do_write(1'b1, 8'h02, 16'h2468);
    chk("R9 busy-time frame not programmed", {15'h0, ready}, 16'h1);
    wait_ready(n);
    chk("R8 ready returns", {15'h0, ready}, 16'h1);
    do_read(1'b1, 8'h02, 0, v, dmy, oes);
    chk("R9 first data kept", v, 16'h1357);

    // R10 aborted write
    sel(1'b1);
    send(3'b101, 3);
    send(32'h02, 7);
    send(32'hF, 4);
    desel();
    chk("R10 no busy after abort", {15'h0, ready}, 16'h1);
    do_read(1'b1, 8'h02, 0, v, dmy, oes);
    chk("R10 data unchanged", v, 16'h1357);

    // R2 leading zeros before start bit
    do_read(1'b1, 8'h02, 3, v, dmy, oes);
    chk("R2 leading zeros skipped", v, 16'h1357);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule